// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits in the command path of an SDRAM model or controller. It keeps the burst settings written by a load-mode command and, for each READ or WRITE, produces the column address of every beat. A command that is registered on one clock edge opens a burst. The column of the first beat is visible after that edge. Each beat-advance strobe steps the burst one beat, and the block drops its valid flag when the last beat has been consumed or when a burst-terminate strobe arrives.

Two beat orderings are supported: a wrapping increment within the aligned block of the burst length, and an interleave in which the beat index is XORed into the low column bits. The burst length can be 1, 2, 4 or 8, or a sequential full page that runs across the whole row until it is terminated. A separate write-mode bit forces writes to a single beat while reads keep the programmed length. Reserved settings in the main or the extended register raise an error flag, and while that flag is high, read and write commands are refused.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid, beat_last and mode_err are 0. The stored mode is burst length 1, sequential ordering, latency code 3, and writes follow the programmed length.
- R2: A command with cmd_op=00 and bank_sel=00 stores addr[9:0] as the mode. Bits [2:0] give the length (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 picks the ordering (0 sequential, 1 interleaved). Bits [6:4] are the latency code. Bits [8:7] are the operating mode. Bit 9 is the write mode. The mode applies to every burst that starts afterwards.
- R3: In sequential ordering with length L of 2, 4 or 8, beat k outputs the low log2(L) column bits equal to (start + k) mod L. For example, length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R4: In interleaved ordering, beat k outputs low column bits equal to the start's low bits XOR k. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: Column bits above the burst-length boundary keep the start column's value on every beat.
- R6: A full-page burst steps through all 9 column bits, wraps from 0x1FF to 0x000, and never raises beat_last. It ends only on burst_stop or on a new command.
- R7: mode_err is 1 in any of these cases: the length code is 100, 101 or 110; the length is full page with interleaved ordering; bits [8:7] are nonzero; or the latency code is other than 2 or 3. While mode_err is 1, READ (cmd_op=01) and WRITE (cmd_op=10) commands are ignored.
- R8: When write mode bit 9 is 1, a WRITE burst has one beat and a READ burst has the programmed length. When bit 9 is 0, both have the programmed length.
- R9: A load with bank_sel=10 writes the extended register, and mode_err is raised when any of addr[12:7] is nonzero in that load. Loads with bank_sel=01 or 11 change nothing.
- R10: beat_valid rises the cycle after a READ or WRITE is registered, with col_addr equal to addr[8:0]. Each beat_adv moves to the next beat one cycle later. beat_last is 1 on the final beat. A beat_adv on the final beat clears beat_valid in the next cycle.
- R11: burst_stop during a burst clears beat_valid in the next cycle, and beat_adv while idle has no effect.
- R12: A load command issued during a burst is ignored: the burst keeps its length and ordering, and the stored mode is unchanged.
- R13: A READ or WRITE issued during a burst restarts the sequence at the new start column on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_en | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 load register, 01 read, 10 write, 11 no operation |
| bank_sel | input | 2 | Register select for loads (00 mode, 10 extended) |
| addr | input | 13 | Register value for loads, start column in bits [8:0] for bursts |
| beat_adv | input | 1 | Consume the current beat |
| burst_stop | input | 1 | Terminate the current burst |
| col_addr | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A burst beat is presented |
| beat_last | output | 1 | The presented beat is the final one |
| mode_err | output | 1 | Stored settings include a reserved value |

## Verification
Every result is due exactly one clock edge after its stimulus. mode_err reflects a load on the edge that registers it. beat_valid and the first column follow the edge that registers the command. Each new column, the beat_last flag and the fall of beat_valid follow the edge that registers beat_adv or burst_stop. The bench changes inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge. Every check therefore lands in the single cycle in which its result should first be visible.

// File: rtl/bcs_pkg.sv
// Package for the burst column sequencer.
// Holds the command encodings, the mode field layout and the length codes.
// Assumes a 10-bit mode field taken from the low bits of the address bus.
package bcs_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NOP   = 2'b11
    } cmd_op_e;

    localparam logic [1:0] SEL_MAIN = 2'b00;
    localparam logic [1:0] SEL_EXT  = 2'b10;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    localparam int MODE_W     = 10;
    localparam int EXT_ZERO_LO = 7;

    // Mode field, most significant first, matching addr[9:0]
    typedef struct packed {
        logic       wr_single;
        logic [1:0] op_mode;
        logic [2:0] latency;
        logic       interleave;
        logic [2:0] len_code;
    } mode_t;

    localparam mode_t MODE_RESET = '{
        wr_single:  1'b0,
        op_mode:    2'b00,
        latency:    3'b011,
        interleave: 1'b0,
        len_code:   LEN_1
    };

    // True for a length code that selects no supported length
    function automatic logic len_code_bad(input logic [2:0] code);
        return !(code inside {LEN_1, LEN_2, LEN_4, LEN_8, LEN_PAGE});
    endfunction

    // True for a latency code other than two or three clocks
    function automatic logic latency_bad(input logic [2:0] code);
        return !(code inside {3'b010, 3'b011});
    endfunction

endpackage

// File: rtl/bcs_mode_regs.sv
// Mode storage for the burst column sequencer.
// Captures the main mode and the extended-register check on a load, decodes
// the length into a column mask, and reports reserved settings.
// Assumes loads are only presented while no burst is active (gated above).
module bcs_mode_regs
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [1:0]        bank_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  len_mask,
    output logic              full_page,
    output logic              interleave,
    output logic              wr_single,
    output logic              mode_err
);

    localparam int EXT_HI_W = ADDR_W - EXT_ZERO_LO;

    mode_t mode_q;
    logic  ext_nz_q;
    logic [EXT_HI_W-1:0] ext_hi;

    assign ext_hi = addr[ADDR_W-1:EXT_ZERO_LO];

    // Register the selected mode register on a load command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            ext_nz_q <= 1'b0;
        end else if (load_en) begin
            if (bank_sel == SEL_MAIN)
                mode_q <= mode_t'(addr[MODE_W-1:0]);
            else if (bank_sel == SEL_EXT)
                ext_nz_q <= |ext_hi;
        end
    end

    // Turn the length code into a mask of the wrapping column bits
    always_comb begin
        case (mode_q.len_code)
            LEN_2:    len_mask = COL_W'(1);
            LEN_4:    len_mask = COL_W'(3);
            LEN_8:    len_mask = COL_W'(7);
            LEN_PAGE: len_mask = '1;
            default:  len_mask = '0;
        endcase
    end

    // Flag every reserved combination of the stored settings
    always_comb begin
        full_page  = (mode_q.len_code == LEN_PAGE);
        interleave = mode_q.interleave;
        wr_single  = mode_q.wr_single;
        mode_err   = len_code_bad(mode_q.len_code)
                   | latency_bad(mode_q.latency)
                   | (mode_q.op_mode != 2'b00)
                   | (full_page & mode_q.interleave)
                   | ext_nz_q;
    end

    // R9
    reserved_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && bank_sel[0]) |=> ($stable(mode_q) && $stable(ext_nz_q)));

    // R2
    main_load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && bank_sel == SEL_MAIN) |=> (mode_q.len_code == $past(addr[2:0])));

endmodule

// File: rtl/bcs_beat_ctrl.sv
// Beat tracking for the burst column sequencer.
// Latches the start column and the burst settings when a burst opens, counts
// beats on each advance, and closes the burst on the last beat or a stop.
// Assumes start is already refused by the caller while settings are reserved.
module bcs_beat_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_write,
    input  logic [COL_W-1:0] start_col,
    input  logic             beat_adv,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] len_mask,
    input  logic             full_page,
    input  logic             interleave,
    input  logic             wr_single,
    output logic             active,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] eff_mask,
    output logic [COL_W-1:0] start_q,
    output logic             inter_q,
    output logic             last
);

    logic full_q;
    logic one_beat;

    assign one_beat = start_write & wr_single;

    // Open, step and close the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            eff_mask <= '0;
            start_q  <= '0;
            inter_q  <= 1'b0;
            full_q   <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            idx      <= '0;
            start_q  <= start_col;
            inter_q  <= interleave;
            eff_mask <= one_beat ? '0 : len_mask;
            full_q   <= full_page & ~one_beat;
        end else if (active && burst_stop) begin
            active <= 1'b0;
        end else if (active && beat_adv) begin
            if (last)
                active <= 1'b0;
            else
                idx <= idx + COL_W'(1);
        end
    end

    // Final beat of a counted burst; a full page has none
    assign last = active & ~full_q & (idx == eff_mask);

    // R10
    last_adv_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && last && beat_adv && !start && !burst_stop) |=> !active);

    // R11
    stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && burst_stop && !start) |=> !active);

    // R5
    start_col_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> $stable(start_q));

    // R3
    idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !full_q) |-> ((idx & ~eff_mask) == '0));

    // R13
    restart_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && idx == '0));

endmodule

// File: rtl/bcs_col_gen.sv
// Column generator for the burst column sequencer.
// Forms each beat's column from the start column and the beat index: bits
// inside the length mask take the incremented or XORed value, the others keep
// the start value. Purely combinational; assumes idx stays inside the mask.
module bcs_col_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] mixed;

    // Both candidate orderings, then the selected one
    always_comb begin
        seq_col = start_col + idx;
        xor_col = start_col ^ idx;
        mixed   = interleave ? xor_col : seq_col;
    end

    // Per bit: wrapping bits follow the ordering, upper bits stay fixed
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = mask[b] ? mixed[b] : start_col[b];
    end

endmodule

// File: rtl/burst_col_seq.sv
// Top of the SDRAM burst column sequencer.
// Decodes the command strobe into loads and burst starts, refuses loads while
// a burst runs and bursts while the settings are reserved, and presents the
// beat column with its valid and last flags.
// Assumes the address bus is at least 10 bits wide and covers the column.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              beat_adv,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              mode_err
);

    logic             active;
    logic             load_en;
    logic             go;
    logic             go_write;
    logic [COL_W-1:0] len_mask;
    logic             full_page;
    logic             interleave;
    logic             wr_single;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] eff_mask;
    logic [COL_W-1:0] start_q;
    logic             inter_q;
    logic             last;

    // Command decode with the busy and error gates
    always_comb begin
        load_en  = cmd_en & (cmd_op == OP_LOAD) & ~active;
        go_write = (cmd_op == OP_WRITE);
        go       = cmd_en & ((cmd_op == OP_READ) | go_write) & ~mode_err;
    end

    bcs_mode_regs #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .bank_sel   (bank_sel),
        .addr       (addr),
        .len_mask   (len_mask),
        .full_page  (full_page),
        .interleave (interleave),
        .wr_single  (wr_single),
        .mode_err   (mode_err)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_beat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (go),
        .start_write (go_write),
        .start_col   (addr[COL_W-1:0]),
        .beat_adv    (beat_adv),
        .burst_stop  (burst_stop),
        .len_mask    (len_mask),
        .full_page   (full_page),
        .interleave  (interleave),
        .wr_single   (wr_single),
        .active      (active),
        .idx         (idx),
        .eff_mask    (eff_mask),
        .start_q     (start_q),
        .inter_q     (inter_q),
        .last        (last)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .start_col  (start_q),
        .idx        (idx),
        .mask       (eff_mask),
        .interleave (inter_q),
        .col        (col_addr)
    );

    assign beat_valid = active;
    assign beat_last  = last;

    // R7
    err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && mode_err && !$past(beat_valid)) |=> !beat_valid);

    // R12
    load_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && cmd_en && cmd_op == OP_LOAD && !beat_adv && !burst_stop)
        |=> (beat_valid && $stable(col_addr) && $stable(mode_err)));

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    localparam int ADDR_W = 13;
    localparam int COL_W  = 9;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_en = 1'b0;
    logic [1:0]        cmd_op = 2'b11;
    logic [1:0]        bank_sel = 2'b00;
    logic [ADDR_W-1:0] addr = '0;
    logic              beat_adv = 1'b0;
    logic              burst_stop = 1'b0;
    logic [COL_W-1:0]  col_addr;
    logic              beat_valid;
    logic              beat_last;
    logic              mode_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
        .bank_sel(bank_sel), .addr(addr), .beat_adv(beat_adv),
        .burst_stop(burst_stop), .col_addr(col_addr), .beat_valid(beat_valid),
        .beat_last(beat_last), .mode_err(mode_err)
    );

    typedef struct packed {
        logic [3:0]            req;
        logic [12:0]           mode;
        logic [1:0]            op;
        logic [8:0]            start;
        logic [3:0]            n;
        logic [0:7][8:0]       cols;
    } vec_t;

    // Expected orders worked out from R3, R4, R5, R8 and R2
    localparam vec_t VECS [0:NVEC-1] = '{
        '{4'd3, 13'h033, 2'b01, 9'h005, 4'd8, {9'h5, 9'h6, 9'h7, 9'h0, 9'h1, 9'h2, 9'h3, 9'h4}},
        '{4'd4, 13'h03B, 2'b01, 9'h005, 4'd8, {9'h5, 9'h4, 9'h7, 9'h6, 9'h1, 9'h0, 9'h3, 9'h2}},
        '{4'd5, 13'h032, 2'b01, 9'h1F6, 4'd4, {9'h1F6, 9'h1F7, 9'h1F4, 9'h1F5, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{4'd4, 13'h03A, 2'b01, 9'h00D, 4'd4, {9'hD, 9'hC, 9'hF, 9'hE, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{4'd3, 13'h031, 2'b01, 9'h033, 4'd2, {9'h33, 9'h32, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{4'd2, 13'h030, 2'b01, 9'h044, 4'd1, {9'h44, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{4'd8, 13'h233, 2'b10, 9'h003, 4'd1, {9'h3, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}},
        '{4'd8, 13'h233, 2'b01, 9'h003, 4'd8, {9'h3, 9'h4, 9'h5, 9'h6, 9'h7, 9'h0, 9'h1, 9'h2}},
        '{4'd8, 13'h033, 2'b10, 9'h10A, 4'd8, {9'h10A, 9'h10B, 9'h10C, 9'h10D, 9'h10E, 9'h10F, 9'h108, 9'h109}},
        '{4'd5, 13'h03B, 2'b01, 9'h1FF, 4'd8, {9'h1FF, 9'h1FE, 9'h1FD, 9'h1FC, 9'h1FB, 9'h1FA, 9'h1F9, 9'h1F8}}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] bank,
                         input logic [ADDR_W-1:0] a);
        @(negedge clk);
        cmd_en = 1'b1; cmd_op = op; bank_sel = bank; addr = a;
        @(negedge clk);
        cmd_en = 1'b0; cmd_op = 2'b11;
    endtask

    task automatic advance();
        @(negedge clk);
        beat_adv = 1'b1;
        @(negedge clk);
        beat_adv = 1'b0;
    endtask

    task automatic stop_burst();
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "valid", beat_valid, 0);
        check("R1", "last", beat_last, 0);
        check("R1", "err", mode_err, 0);
        // R1 default mode: single-beat sequential burst
        issue(2'b01, 2'b00, 13'h012);
        check("R1", "default col", col_addr, 9'h012);
        check("R1", "default last", beat_last, 1);
        advance();
        check("R10", "valid after last", beat_valid, 0);

        // Table walk: R2 R3 R4 R5 R8 R10
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            issue(2'b00, 2'b00, VECS[i].mode);
            check(tag, "err after load", mode_err, 0);
            issue(VECS[i].op, 2'b00, {4'b0, VECS[i].start});
            check("R10", "valid at start", beat_valid, 1);
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                check(tag, $sformatf("vec %0d beat %0d col", i, k), col_addr, VECS[i].cols[k]);
                check("R10", $sformatf("vec %0d beat %0d last", i, k), beat_last,
                      (k == int'(VECS[i].n) - 1) ? 1 : 0);
                advance();
            end
            check("R10", $sformatf("vec %0d valid after end", i), beat_valid, 0);
        end

        // R6 full page wraps and never ends by itself; R11 stop ends it
        issue(2'b00, 2'b00, 13'h037);
        check("R6", "err page seq", mode_err, 0);
        issue(2'b01, 2'b00, 13'h1FE);
        check("R6", "col 0", col_addr, 9'h1FE);
        check("R6", "last 0", beat_last, 0);
        advance();
        check("R6", "col 1", col_addr, 9'h1FF);
        advance();
        check("R6", "col wrap", col_addr, 9'h000);
        check("R6", "last at wrap", beat_last, 0);
        advance();
        check("R6", "col 3", col_addr, 9'h001);
        check("R6", "still valid", beat_valid, 1);
        stop_burst();
        check("R11", "valid after stop", beat_valid, 0);

        // R7 reserved settings
        issue(2'b00, 2'b00, 13'h03F);
        check("R7", "page interleave err", mode_err, 1);
        issue(2'b01, 2'b00, 13'h005);
        check("R7", "read refused", beat_valid, 0);
        issue(2'b10, 2'b00, 13'h005);
        check("R7", "write refused", beat_valid, 0);
        issue(2'b00, 2'b00, 13'h034);
        check("R7", "length code 100 err", mode_err, 1);
        issue(2'b00, 2'b00, 13'h0B3);
        check("R7", "op mode err", mode_err, 1);
        issue(2'b00, 2'b00, 13'h013);
        check("R7", "latency err", mode_err, 1);
        issue(2'b00, 2'b00, 13'h033);
        check("R7", "err clears", mode_err, 0);

        // R9 extended register and reserved selects
        issue(2'b00, 2'b10, 13'h0080);
        check("R9", "ext reserved bit err", mode_err, 1);
        issue(2'b00, 2'b10, 13'h007F);
        check("R9", "ext clean", mode_err, 0);
        issue(2'b00, 2'b01, 13'h0034);
        check("R9", "select 01 ignored", mode_err, 0);
        issue(2'b00, 2'b11, 13'h0034);
        check("R9", "select 11 ignored", mode_err, 0);
        issue(2'b01, 2'b00, 13'h006);
        check("R9", "mode kept col", col_addr, 9'h006);
        advance();
        check("R9", "mode kept step", col_addr, 9'h007);
        advance();
        check("R9", "mode kept wrap", col_addr, 9'h000);

        // R12 load during burst ignored
        issue(2'b00, 2'b00, 13'h030);
        check("R12", "burst continues", beat_valid, 1);
        check("R12", "col held", col_addr, 9'h000);
        repeat (4) advance();
        check("R12", "col after steps", col_addr, 9'h004);
        check("R12", "not last yet", beat_last, 0);
        advance();
        check("R12", "final col", col_addr, 9'h005);
        check("R12", "final last", beat_last, 1);
        advance();
        check("R12", "ended", beat_valid, 0);
        issue(2'b01, 2'b00, 13'h001);
        check("R12", "length kept", beat_last, 0);
        advance();
        check("R13", "before restart", col_addr, 9'h002);

        // R13 restart mid burst
        issue(2'b01, 2'b00, 13'h01C);
        check("R13", "restart col", col_addr, 9'h01C);
        check("R13", "restart valid", beat_valid, 1);
        advance();
        check("R13", "restart step", col_addr, 9'h01D);

        // R11 stop and idle advance
        stop_burst();
        check("R11", "stopped", beat_valid, 0);
        advance();
        check("R11", "idle advance", beat_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule